// File: doc/BRIEF.md
# Video Display Field Notification Controller

This block sits between a raster timing generator and the display FIFO and DMA machinery of a video output engine. At every field start it samples the display controls: the master enable, continuous mode, frame mode and the two per-field enables. It then decides whether the coming field is displayed. A displayed field raises DMA refill requests while the FIFO runs low inside the active window, and it sends FIFO data to the pixel output. A field that is not displayed asks for no data and shows a programmable default pixel. The display-enable timing output keeps running for every field either way.

When continuous mode is off, the block flags the end of each displayed field or frame in status bits. The processor clears these bits by writing 1. If the processor has not cleared a completion bit by the time the next displayed field starts, the block emits a one-cycle not-acknowledged interrupt and keeps a sticky record of it. DMA requests carry on as normal in that case.

Top module: `vid_field_notify`

## Requirements
- R1: `de_out` equals `active` delayed by one clock in every field, whatever the enables and modes are.
- R2: A field whose start is sampled with `disp_en` = 0 is not displayed: no `dma_req`, and `pix_out` shows `default_pix` in the active window.
- R3: With `cont_mode` = 1 at field start, no completion status bit is set at field end and no interrupt is raised at field start.
- R4: In field mode (`frame_mode` = 0, `cont_mode` = 0), the end of a displayed field 1 (`field_id` = 0) sets `status[0]`, and the end of a displayed field 2 (`field_id` = 1) sets `status[1]`.
- R5: In frame mode (`cont_mode` = 0), only `status[2]` is set. It is set at the end of field 2 when field 2 is enabled, or at the end of field 1 when field 2 is disabled.
- R6: At the start of a displayed field with `cont_mode` = 0, if any of `status[2:0]` is still set, `nack_irq` pulses high for exactly the one cycle after the start and `status[3]` becomes set. Displaying proceeds normally.
- R7: During a field that is not displayed, `dma_req` stays low.
- R8: `pix_out` is registered, one clock after the inputs. In the active window it shows `fifo_data` for a displayed field and `default_pix` otherwise. Outside the window it is 0.
- R9: `dma_req` is high in the cycle after a clock in which `active` = 1, the field is displayed and `fifo_level` < `fifo_thresh`. Otherwise it is low.
- R10: Writing 1 to a bit of `status_clr` clears that status bit. If a set event arrives in the same cycle, the bit stays set.
- R11: The enables and modes are sampled only at `field_start`. Changing them mid-field has no effect on that field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| field_start | input | 1 | One-cycle strobe at the start of a field |
| field_id | input | 1 | Field starting: 0 = field 1, 1 = field 2 |
| field_end | input | 1 | One-cycle strobe at the end of a field |
| active | input | 1 | Active image window |
| disp_en | input | 1 | Master display enable |
| cont_mode | input | 1 | Continuous display, no completion handshake |
| frame_mode | input | 1 | Report per frame instead of per field |
| f1_en | input | 1 | Field 1 display enable |
| f2_en | input | 1 | Field 2 display enable |
| fifo_level | input | LVL_W | Display FIFO fill level |
| fifo_thresh | input | LVL_W | Refill threshold |
| fifo_data | input | PIX_W | Pixel from the FIFO |
| default_pix | input | PIX_W | Pixel shown in non-displayed fields |
| status_clr | input | 4 | Write-1-to-clear strobes for the status bits |
| dma_req | output | 1 | DMA refill request |
| pix_out | output | PIX_W | Registered pixel output |
| de_out | output | 1 | Registered active-window timing |
| status | output | 4 | [0] field 1 done, [1] field 2 done, [2] frame done, [3] not-acknowledged sticky |
| nack_irq | output | 1 | Not-acknowledged interrupt pulse |

## Verification
Fields are run in continuous mode, in field mode with both fields enabled, and in frame mode with one and with both fields enabled. Comparing these shows whether the status bit chosen depends on the mode and on which fields are enabled. Fields are also run with the master enable off and with one field disabled. These separate gating by the per-field enables from gating by the master enable, and show that the default pixel and the missing requests line up with the sampled enables. One field starts with an uncleared completion bit to provoke the interrupt. Other fields change the controls mid-field or clear a bit in the same cycle it is set, to separate sampling at field start from live decoding and to confirm that a set wins over a clear.

// File: rtl/vdn_pkg.sv
// Package: shared status bit positions and the per-field configuration record.
package vdn_pkg;
    localparam int ST_F1   = 0;
    localparam int ST_F2   = 1;
    localparam int ST_FRM  = 2;
    localparam int ST_NACK = 3;
    localparam int ST_W    = 4;

    typedef struct packed {
        logic en;     // field is displayed
        logic cont;   // continuous mode for this field
        logic frame;  // frame reporting for this field
        logic fid;    // 0 = field 1, 1 = field 2
        logic f2_en;  // field 2 enable as sampled
    } fld_cfg_t;
endpackage

// File: rtl/vdn_field_ctl.sv
// Field controller: samples the display controls at each field start and
// derives the completion set events and the not-acknowledged interrupt.
// Assumes field_start and field_end are single-cycle strobes that never
// coincide, and that field starts are at least two cycles apart.
module vdn_field_ctl
    import vdn_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            field_start,
    input  logic            field_id,
    input  logic            field_end,
    input  logic            disp_en,
    input  logic            cont_mode,
    input  logic            frame_mode,
    input  logic            f1_en,
    input  logic            f2_en,
    input  logic            done_any,
    output fld_cfg_t        cfg,
    output logic [ST_W-1:0] set_vec,
    output logic            irq_o
);
    logic fen_now;
    logic nack_hit;
    logic fin;

    // Purpose: enable that applies to the field now starting.
    assign fen_now  = field_id ? f2_en : f1_en;
    // Purpose: an uncleared completion bit is seen as a displayed field starts.
    assign nack_hit = field_start & disp_en & fen_now & ~cont_mode & done_any;

    // Purpose: latch the field configuration at every field start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= '0;
        end else if (field_start) begin
            cfg.en    <= disp_en & fen_now;
            cfg.cont  <= cont_mode;
            cfg.frame <= frame_mode;
            cfg.fid   <= field_id;
            cfg.f2_en <= f2_en;
        end
    end

    // Purpose: register the interrupt pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_o <= 1'b0;
        else        irq_o <= nack_hit;
    end

    // Purpose: decode the completion set events at field end.
    always_comb begin
        fin              = field_end & cfg.en & ~cfg.cont;
        set_vec          = '0;
        set_vec[ST_F1]   = fin & ~cfg.frame & ~cfg.fid;
        set_vec[ST_F2]   = fin & ~cfg.frame &  cfg.fid;
        set_vec[ST_FRM]  = fin &  cfg.frame & (cfg.fid | ~cfg.f2_en);
        set_vec[ST_NACK] = nack_hit;
    end

    a_r6_irq_after_start: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> $past(field_start));

    a_r11_cfg_held: assert property (@(posedge clk) disable iff (!rst_n)
        !field_start |=> $stable(cfg));

    a_r3_cont_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (field_start && cont_mode) |=> !irq_o);
endmodule

// File: rtl/vdn_status.sv
// Status register: write-1-to-clear bits, where a set event beats a clear
// arriving in the same cycle.
module vdn_status
    import vdn_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [ST_W-1:0] set_i,
    input  logic [ST_W-1:0] clr_i,
    output logic [ST_W-1:0] stat_o
);
    // Purpose: one generated flop per status bit.
    for (genvar k = 0; k < ST_W; k++) begin : g_bit
        always_ff @(posedge clk) begin
            if (!rst_n)        stat_o[k] <= 1'b0;
            else if (set_i[k]) stat_o[k] <= 1'b1;
            else if (clr_i[k]) stat_o[k] <= 1'b0;
        end

        a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[k] |=> stat_o[k]);

        a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i[k] && !set_i[k]) |=> !stat_o[k]);
    end
endmodule

// File: rtl/vdn_pixpath.sv
// Pixel path: registered refill requests, pixel select and timing output.
// Assumes en_i is steady for the whole active window of a field.
module vdn_pixpath #(
    parameter int LVL_W = 6,
    parameter int PIX_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active_i,
    input  logic             en_i,
    input  logic [LVL_W-1:0] level_i,
    input  logic [LVL_W-1:0] thresh_i,
    input  logic [PIX_W-1:0] fifo_data_i,
    input  logic [PIX_W-1:0] default_i,
    output logic             dma_req_o,
    output logic [PIX_W-1:0] pix_o,
    output logic             de_o
);
    localparam logic [PIX_W-1:0] BLANK = '0;

    // Purpose: request, pixel and timing registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dma_req_o <= 1'b0;
            pix_o     <= BLANK;
            de_o      <= 1'b0;
        end else begin
            dma_req_o <= active_i & en_i & (level_i < thresh_i);
            de_o      <= active_i;
            if (!active_i)  pix_o <= BLANK;
            else if (en_i)  pix_o <= fifo_data_i;
            else            pix_o <= default_i;
        end
    end

    a_r9_req_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req_o |-> $past(active_i));

    a_r7_no_req_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req_o |-> $past(en_i));

    a_r1_de_follows: assert property (@(posedge clk) disable iff (!rst_n)
        $past(active_i) |-> de_o);
endmodule

// File: rtl/vid_field_notify.sv
// Top: per-field display gating and completion notification for a video
// output engine. Raster timing, FIFO storage and the DMA engine are external.
module vid_field_notify
    import vdn_pkg::*;
#(
    parameter int LVL_W = 6,
    parameter int PIX_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             field_start,
    input  logic             field_id,
    input  logic             field_end,
    input  logic             active,
    input  logic             disp_en,
    input  logic             cont_mode,
    input  logic             frame_mode,
    input  logic             f1_en,
    input  logic             f2_en,
    input  logic [LVL_W-1:0] fifo_level,
    input  logic [LVL_W-1:0] fifo_thresh,
    input  logic [PIX_W-1:0] fifo_data,
    input  logic [PIX_W-1:0] default_pix,
    input  logic [3:0]       status_clr,
    output logic             dma_req,
    output logic [PIX_W-1:0] pix_out,
    output logic             de_out,
    output logic [3:0]       status,
    output logic             nack_irq
);
    fld_cfg_t        cfg;
    logic [ST_W-1:0] set_vec;
    logic            done_any;

    // Purpose: any completion bit still waiting for acknowledgement.
    assign done_any = status[ST_F1] | status[ST_F2] | status[ST_FRM];

    vdn_field_ctl u_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .field_start(field_start),
        .field_id   (field_id),
        .field_end  (field_end),
        .disp_en    (disp_en),
        .cont_mode  (cont_mode),
        .frame_mode (frame_mode),
        .f1_en      (f1_en),
        .f2_en      (f2_en),
        .done_any   (done_any),
        .cfg        (cfg),
        .set_vec    (set_vec),
        .irq_o      (nack_irq)
    );

    vdn_status u_stat (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (set_vec),
        .clr_i (status_clr),
        .stat_o(status)
    );

    vdn_pixpath #(.LVL_W(LVL_W), .PIX_W(PIX_W)) u_pix (
        .clk        (clk),
        .rst_n      (rst_n),
        .active_i   (active),
        .en_i       (cfg.en),
        .level_i    (fifo_level),
        .thresh_i   (fifo_thresh),
        .fifo_data_i(fifo_data),
        .default_i  (default_pix),
        .dma_req_o  (dma_req),
        .pix_o      (pix_out),
        .de_o       (de_out)
    );

    a_r6_sticky_with_irq: assert property (@(posedge clk) disable iff (!rst_n)
        nack_irq |-> status[ST_NACK]);
endmodule

// File: tb/tb_vid_field_notify.sv
module tb_vid_field_notify;
    localparam int LVL_W = 6;
    localparam int PIX_W = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic field_start = 0, field_id = 0, field_end = 0, active = 0;
    logic disp_en = 0, cont_mode = 0, frame_mode = 0, f1_en = 0, f2_en = 0;
    logic [LVL_W-1:0] fifo_level = '0, fifo_thresh = 6'd3;
    logic [PIX_W-1:0] fifo_data = '0, default_pix = 10'h155;
    logic [3:0] status_clr = '0;
    logic dma_req, de_out, nack_irq;
    logic [PIX_W-1:0] pix_out;
    logic [3:0] status;

    int total = 0, bad = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    vid_field_notify #(.LVL_W(LVL_W), .PIX_W(PIX_W)) dut (.*);

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One field: start, optional mid-field control flip, active window, end.
    task automatic run_field(input bit fid, input bit exp_en, input bit exp_irq,
                             input bit flip, input logic [3:0] clr_end,
                             input logic [3:0] exp_stat, input string tag);
        logic s_d, s_1, s_2, s_c;
        field_id = fid; field_start = 1; step(); field_start = 0;
        chk(nack_irq == exp_irq, {tag, " R6 irq"}, nack_irq, exp_irq);
        s_d = disp_en; s_1 = f1_en; s_2 = f2_en; s_c = cont_mode;
        if (flip) begin disp_en = ~disp_en; f1_en = ~f1_en; f2_en = ~f2_en; cont_mode = ~cont_mode; end
        step();
        chk(nack_irq == 0, {tag, " R6 pulse"}, nack_irq, 0);
        for (int i = 0; i < 6; i++) begin
            active = 1; fifo_level = LVL_W'(i); fifo_data = PIX_W'(10'h0A0 + i);
            step();
            chk(de_out == 1, {tag, " R1 de"}, de_out, 1);
            chk(dma_req == (exp_en && i < 3), {tag, " R9/R7 req"}, dma_req, exp_en && i < 3);
            chk(pix_out == (exp_en ? PIX_W'(10'h0A0 + i) : default_pix),
                {tag, " R8/R2 pix"}, pix_out, exp_en ? 10'h0A0 + i : default_pix);
        end
        active = 0; fifo_level = '0; step();
        chk(de_out == 0 && pix_out == 0 && dma_req == 0, {tag, " R8 blank"}, pix_out, 0);
        field_end = 1; status_clr = clr_end; step(); field_end = 0; status_clr = '0;
        chk(status == exp_stat, {tag, " status"}, status, exp_stat);
        if (flip) begin disp_en = s_d; f1_en = s_1; f2_en = s_2; cont_mode = s_c; end
        step();
    endtask

    task automatic w1c(input logic [3:0] m, input logic [3:0] exp, input string tag);
        status_clr = m; step(); status_clr = '0;
        chk(status == exp, {tag, " R10 clear"}, status, exp);
    endtask

    task automatic t_reset();
        step();
        chk(status == 0 && dma_req == 0 && nack_irq == 0 && pix_out == 0 && de_out == 0,
            "reset", status, 0);
        rst_n = 1; step();
    endtask

    task automatic t_cont();   // R3
        disp_en = 1; cont_mode = 1; frame_mode = 0; f1_en = 1; f2_en = 1;
        run_field(0, 1, 0, 0, 4'h0, 4'h0, "R3 cont f1");
        run_field(1, 1, 0, 0, 4'h0, 4'h0, "R3 cont f2");
        run_field(0, 1, 0, 0, 4'h0, 4'h0, "R3 cont again");
    endtask

    task automatic t_field();  // R4, R6, R10
        cont_mode = 0;
        run_field(0, 1, 0, 0, 4'h0, 4'h1, "R4 f1 done");
        w1c(4'h1, 4'h0, "R4");
        run_field(1, 1, 0, 0, 4'h0, 4'h2, "R4 f2 done");
        run_field(0, 1, 1, 0, 4'h0, 4'hB, "R6 nack");
        w1c(4'hF, 4'h0, "R6");
    endtask

    task automatic t_frame();  // R5, R7, R8
        frame_mode = 1;
        run_field(0, 1, 0, 0, 4'h0, 4'h0, "R5 frame f1");
        run_field(1, 1, 0, 0, 4'h0, 4'h4, "R5 frame f2");
        w1c(4'h4, 4'h0, "R5");
        f2_en = 0;
        run_field(0, 1, 0, 0, 4'h0, 4'h4, "R5 frame f2 off");
        run_field(1, 0, 0, 0, 4'h0, 4'h4, "R7 field disabled");
        w1c(4'h4, 4'h0, "R5 b");
        frame_mode = 0; f2_en = 1;
    endtask

    task automatic t_disp_off(); // R2
        disp_en = 0;
        run_field(0, 0, 0, 0, 4'h0, 4'h0, "R2 master off");
        disp_en = 1;
    endtask

    task automatic t_hold();   // R11, R10 set wins
        run_field(0, 1, 0, 1, 4'h0, 4'h1, "R11 flip on");
        w1c(4'h1, 4'h0, "R11");
        disp_en = 0;
        run_field(1, 0, 0, 1, 4'h0, 4'h0, "R11 flip off");
        disp_en = 1;
        run_field(0, 1, 0, 0, 4'h1, 4'h1, "R10 set wins");
        w1c(4'h1, 4'h0, "R10 after");
    endtask

    initial begin
        t_reset();
        t_cont();
        t_field();
        t_frame();
        t_disp_off();
        t_hold();
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(20 * 100000);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog R1 actual=%0d expected=%0d", 0, 1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule